// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block carries out one atomic memory operation at a time against a single-ported memory whose words are 64 bits wide. A decoded request carries the 5-bit operation code, the 3-bit width code, a byte address and the source operand. For a read-modify-write operation, the unit reads the target word. It then computes the new value from the loaded data and the operand, writes that value back, and returns the value it loaded. For a load-reserved operation, it reads the word and records the address in a local reservation register. A store-conditional writes the operand only if that reservation is still valid for the same address. The requester receives a status value: zero means the store was made and one means it was refused.

A 32-bit access works on one half of the memory word, chosen by address bit 2. The loaded half is sign-extended before it is returned and before it is used in the computation. Only the chosen half is written back, through byte enables. The unit handles one request at a time and holds `busy` while it works. The result is valid in the single cycle in which `done` is high. Because every operation runs to completion before the next one is accepted, the ordering between operations is always strict.

Top module: `amo_unit`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `mem_rd` and `mem_wr` are low, and no reservation is held, so a store-conditional issued first returns 1.
- R2: Operation codes 00001 swap, 00000 add, 00100 xor, 01100 and, 01000 or. The stored value is the loaded value combined with the operand (swap stores the operand). `rd_data` returns the loaded value.
- R3: Code 10000 stores the signed minimum and 10100 the signed maximum. Code 11000 stores the unsigned minimum and 11100 the unsigned maximum.
- R4: Width code 011 accesses the whole 64-bit word. Width code 010 accesses the 32-bit half selected by address bit 2 (1 = upper), sign-extends the loaded half to 64 bits, and writes only that half (mask 8'h0F or 8'hF0).
- R5: A read-modify-write operation raises `mem_rd` for one cycle, then `mem_wr` exactly two cycles later, then `done` in the following cycle. There is no other memory strobe between them, and requests that arrive while `busy` is high, or during `done`, are ignored.
- R6: Load-reserved (code 00010) performs one read and no write. It returns the loaded value, with the same width rules as R4, and sets the reservation to the request address. `done` rises three cycles after acceptance.
- R7: Store-conditional (code 00011) writes the operand and returns 0 when the reservation is valid and its address equals the request address. Otherwise it writes nothing and returns 1. Every accepted store-conditional clears the reservation.
- R8: A 32-bit request with address bits [1:0] not zero, or a 64-bit request with bits [2:0] not zero, makes no memory access. It returns `done` with `err` high and `rd_data` zero in the cycle after acceptance.
- R9: An operation code outside the eleven listed, or a width code other than 010 or 011, is handled like R8.
- R10: `mem_rd` and `mem_wr` are never high together, and `done` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; taken only when idle |
| req_funct5 | input | 5 | Operation code |
| req_funct3 | input | 3 | Width code (010 = 32-bit, 011 = 64-bit) |
| req_addr | input | AW | Byte address |
| req_rs2 | input | XLEN | Source operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion without access (misaligned or illegal) |
| rd_data | output | XLEN | Loaded value or store-conditional status, valid with `done` |
| mem_rd | output | 1 | Memory read strobe; data is expected on the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW-3 | Memory word index |
| mem_wdata | output | XLEN | Write data |
| mem_wmask | output | XLEN/8 | Byte enables for the write |
| mem_rdata | input | XLEN | Read data, one cycle after `mem_rd` |

## Verification
Two events can land in the same cycle: the completion of one operation, and a new request from a requester that is eager to issue its next one. The bench holds a second request valid from the cycle after acceptance through the whole operation, including the `done` cycle. It then checks that only the first operation's single read and single write occurred and that the second target word is untouched. A second collision is a store-conditional issued immediately after a load-reserved completes. The bench judges it by the returned status and by the memory contents.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CALC,
        ST_WRITE,
        ST_RESP
    } amo_state_e;

    typedef enum logic [3:0] {
        OP_SWAP,
        OP_ADD,
        OP_XOR,
        OP_AND,
        OP_OR,
        OP_MIN,
        OP_MAX,
        OP_MINU,
        OP_MAXU,
        OP_LR,
        OP_SC,
        OP_BAD
    } amo_op_e;

    localparam logic [2:0] W_WORD  = 3'b010;
    localparam logic [2:0] W_DWORD = 3'b011;

    function automatic amo_op_e amo_decode(input logic [4:0] code);
        amo_op_e op;
        case (code)
            5'b00001: op = OP_SWAP;
            5'b00000: op = OP_ADD;
            5'b00100: op = OP_XOR;
            5'b01100: op = OP_AND;
            5'b01000: op = OP_OR;
            5'b10000: op = OP_MIN;
            5'b10100: op = OP_MAX;
            5'b11000: op = OP_MINU;
            5'b11100: op = OP_MAXU;
            5'b00010: op = OP_LR;
            5'b00011: op = OP_SC;
            default:  op = OP_BAD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  amo_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    logic s_lt;
    logic u_lt;

    always_comb begin
        s_lt = $signed(a) < $signed(b);
        u_lt = a < b;
        unique case (op)
            OP_ADD:  y = a + b;
            OP_XOR:  y = a ^ b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_MIN:  y = s_lt ? a : b;
            OP_MAX:  y = s_lt ? b : a;
            OP_MINU: y = u_lt ? a : b;
            OP_MAXU: y = u_lt ? b : a;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/amo_lane.sv
module amo_lane #(
    parameter int XLEN = 64
) (
    input  logic              wide,
    input  logic              hi,
    input  logic [XLEN-1:0]   rdata,
    input  logic [XLEN-1:0]   rs2,
    input  logic [XLEN-1:0]   store_val,
    output logic [XLEN-1:0]   load_ext,
    output logic [XLEN-1:0]   rs2_ext,
    output logic [XLEN-1:0]   wdata,
    output logic [XLEN/8-1:0] wmask
);
    localparam int HALF = XLEN / 2;
    localparam int BE   = XLEN / 8;

    logic [HALF-1:0] lane;

    always_comb begin
        lane     = hi ? rdata[XLEN-1:HALF] : rdata[HALF-1:0];
        load_ext = wide ? rdata : {{HALF{lane[HALF-1]}}, lane};
        rs2_ext  = wide ? rs2 : {{HALF{rs2[HALF-1]}}, rs2[HALF-1:0]};
        wdata    = wide ? store_val : {2{store_val[HALF-1:0]}};
        if (wide)
            wmask = '1;
        else if (hi)
            wmask = {{(BE/2){1'b1}}, {(BE/2){1'b0}}};
        else
            wmask = {{(BE/2){1'b0}}, {(BE/2){1'b1}}};
    end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set,
    input  logic          clr,
    input  logic [AW-1:0] set_addr,
    input  logic [AW-1:0] cmp_addr,
    output logic          hit
);
    logic          valid_d, valid_q;
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        valid_d = valid_q;
        addr_d  = addr_q;
        if (set) begin
            valid_d = 1'b1;
            addr_d  = set_addr;
        end else if (clr) begin
            valid_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            valid_q <= valid_d;
            addr_q  <= addr_d;
        end
    end

    assign hit = valid_q && (addr_q == cmp_addr);
endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int AW   = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [4:0]              req_funct5,
    input  logic [2:0]              req_funct3,
    input  logic [AW-1:0]           req_addr,
    input  logic [XLEN-1:0]         req_rs2,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic [XLEN-1:0]         rd_data,
    output logic                    mem_rd,
    output logic                    mem_wr,
    output logic [AW-$clog2(XLEN/8)-1:0] mem_addr,
    output logic [XLEN-1:0]         mem_wdata,
    output logic [XLEN/8-1:0]       mem_wmask,
    input  logic [XLEN-1:0]         mem_rdata
);
    localparam int BE  = XLEN / 8;
    localparam int LSB = $clog2(BE);

    typedef struct packed {
        amo_state_e      st;
        amo_op_e         op;
        logic            wide;
        logic [AW-1:0]   addr;
        logic [XLEN-1:0] rd;
        logic [XLEN-1:0] rs2;
        logic [XLEN-1:0] newv;
        logic            err;
    } amo_regs_t;

    amo_regs_t d, q;

    amo_op_e         req_op;
    logic            req_wide;
    logic            req_bad;
    logic            req_mis;
    logic            resv_set;
    logic            resv_clr;
    logic            resv_hit;
    logic [XLEN-1:0] load_ext;
    logic [XLEN-1:0] rs2_ext;
    logic [XLEN-1:0] alu_y;

    amo_lane #(.XLEN(XLEN)) u_lane (
        .wide      (q.wide),
        .hi        (q.addr[LSB-1]),
        .rdata     (mem_rdata),
        .rs2       (q.rs2),
        .store_val (q.newv),
        .load_ext  (load_ext),
        .rs2_ext   (rs2_ext),
        .wdata     (mem_wdata),
        .wmask     (mem_wmask)
    );

    amo_alu #(.XLEN(XLEN)) u_alu (
        .op (q.op),
        .a  (load_ext),
        .b  (rs2_ext),
        .y  (alu_y)
    );

    amo_resv #(.AW(AW)) u_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (resv_set),
        .clr      (resv_clr),
        .set_addr (q.addr),
        .cmp_addr (req_addr),
        .hit      (resv_hit)
    );

    always_comb begin
        req_op   = amo_decode(req_funct5);
        req_wide = (req_funct3 == W_DWORD);
        req_bad  = (req_op == OP_BAD) ||
                   ((req_funct3 != W_WORD) && (req_funct3 != W_DWORD));
        req_mis  = req_wide ? (req_addr[LSB-1:0] != '0)
                            : (req_addr[LSB-2:0] != '0);
    end

    always_comb begin
        d        = q;
        resv_set = 1'b0;
        resv_clr = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.op   = req_op;
                    d.wide = req_wide;
                    d.addr = req_addr;
                    d.rs2  = req_rs2;
                    d.newv = req_rs2;
                    d.rd   = '0;
                    d.err  = 1'b0;
                    if (req_bad || req_mis) begin
                        d.err = 1'b1;
                        d.st  = ST_RESP;
                    end else if (req_op == OP_SC) begin
                        resv_clr = 1'b1;
                        if (resv_hit) begin
                            d.st = ST_WRITE;
                        end else begin
                            d.rd = XLEN'(1);
                            d.st = ST_RESP;
                        end
                    end else begin
                        d.st = ST_READ;
                    end
                end
            end
            ST_READ: d.st = ST_CALC;
            ST_CALC: begin
                d.rd = load_ext;
                if (q.op == OP_LR) begin
                    resv_set = 1'b1;
                    d.st     = ST_RESP;
                end else begin
                    d.newv = alu_y;
                    d.st   = ST_WRITE;
                end
            end
            ST_WRITE: d.st = ST_RESP;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, op: OP_SWAP, wide: 1'b0, addr: '0,
                   rd: '0, rs2: '0, newv: '0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != ST_IDLE);
    assign done     = (q.st == ST_RESP);
    assign err      = done && q.err;
    assign rd_data  = q.rd;
    assign mem_rd   = (q.st == ST_READ);
    assign mem_wr   = (q.st == ST_WRITE);
    assign mem_addr = q.addr[AW-1:LSB];
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic mem_rd,
    input logic mem_wr
);
    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_read_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (busy && !mem_rd && !mem_wr && !done));

    p_write_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> done);

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!$past(mem_rd) && !$past(mem_wr)));
endmodule

bind amo_unit amo_unit_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr)
);

// File: tb/tb_amo_unit.sv
module tb_amo_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_funct5 = '0;
    logic [2:0]  req_funct3 = '0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_rs2 = '0;
    logic        busy, done, err, mem_rd, mem_wr;
    logic [63:0] rd_data, mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic [8:0]  mem_addr;
    logic [7:0]  mem_wmask;

    logic [63:0] mem [0:31];
    int rd_cnt = 0, wr_cnt = 0, both_cnt = 0, dbl_done = 0;
    logic done_prev = 1'b0;
    int nchk = 0, nfail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    amo_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_funct5(req_funct5), .req_funct3(req_funct3),
        .req_addr(req_addr), .req_rs2(req_rs2), .busy(busy),
        .done(done), .err(err), .rd_data(rd_data), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wmask(mem_wmask), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem[mem_addr[4:0]];
            rd_cnt    <= rd_cnt + 1;
        end
        if (mem_wr) begin
            for (int b = 0; b < 8; b++)
                if (mem_wmask[b]) mem[mem_addr[4:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_rd && mem_wr) both_cnt <= both_cnt + 1;
        if (done && done_prev) dbl_done <= dbl_done + 1;
        done_prev <= done;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_alu(input logic [4:0] f5, input logic [63:0] a, input logic [63:0] b);
        case (f5)
            5'b00001: return b;
            5'b00000: return a + b;
            5'b00100: return a ^ b;
            5'b01100: return a & b;
            5'b01000: return a | b;
            5'b10000: return ($signed(a) < $signed(b)) ? a : b;
            5'b10100: return ($signed(a) > $signed(b)) ? a : b;
            5'b11000: return (a < b) ? a : b;
            default:  return (a > b) ? a : b;
        endcase
    endfunction

    task automatic run_op(input logic [4:0] f5, input logic [2:0] f3, input logic [11:0] a,
                          input logic [63:0] v, output logic [63:0] rd, output logic e,
                          output int cyc);
        @(negedge clk);
        req_valid = 1'b1; req_funct5 = f5; req_funct3 = f3; req_addr = a; req_rs2 = v;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        rd = rd_data;
        e  = err;
        @(negedge clk);
    endtask

    task automatic do_amo(input string req, input logic [4:0] f5, input logic wide,
                          input logic [11:0] a, input logic [63:0] v);
        logic [63:0] old, exp_rd, exp_word, av, bv, res, rd;
        logic [31:0] lane;
        logic e;
        int cyc, r0, w0;
        old = mem[a[7:3]];
        if (wide) begin
            exp_rd = old;
            exp_word = ref_alu(f5, old, v);
        end else begin
            lane = a[2] ? old[63:32] : old[31:0];
            av = {{32{lane[31]}}, lane};
            bv = {{32{v[31]}}, v[31:0]};
            res = ref_alu(f5, av, bv);
            exp_rd = av;
            exp_word = a[2] ? {res[31:0], old[31:0]} : {old[63:32], res[31:0]};
        end
        r0 = rd_cnt; w0 = wr_cnt;
        run_op(f5, wide ? 3'b011 : 3'b010, a, v, rd, e, cyc);
        chk({req, " rd"}, rd, exp_rd);
        chk({req, " mem"}, mem[a[7:3]], exp_word);
        chk({req, " err"}, 64'(e), 64'd0);
        chk("R5 amo latency", 64'(cyc), 64'd4);
        chk("R5 one read one write", 64'((rd_cnt - r0) * 16 + (wr_cnt - w0)), 64'd17);
    endtask

    task automatic t_reset;
        logic [63:0] rd; logic e; int cyc, w0; logic [63:0] old;
        chk("R1 busy", 64'(busy), 0);
        chk("R1 done", 64'(done), 0);
        chk("R1 err", 64'(err), 0);
        chk("R1 strobes", 64'({mem_rd, mem_wr}), 0);
        old = mem[0]; w0 = wr_cnt;
        run_op(5'b00011, 3'b011, 12'd0, 64'hAAAA, rd, e, cyc);
        chk("R1 sc without reservation", rd, 64'd1);
        chk("R1 no write", 64'(wr_cnt - w0), 0);
        chk("R1 mem kept", mem[0], old);
    endtask

    task automatic t_dword;
        do_amo("R2 swap", 5'b00001, 1'b1, 12'd8, 64'h1111_2222_3333_4444);
        do_amo("R2 add", 5'b00000, 1'b1, 12'd8, 64'h0000_0001_0000_0001);
        do_amo("R2 xor", 5'b00100, 1'b1, 12'd8, 64'hFF00_FF00_FF00_FF00);
        do_amo("R2 and", 5'b01100, 1'b1, 12'd8, 64'h0F0F_0F0F_F0F0_F0F0);
        do_amo("R2 or", 5'b01000, 1'b1, 12'd8, 64'h8000_0000_0000_0001);
    endtask

    task automatic t_minmax;
        mem[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        do_amo("R3 min signed", 5'b10000, 1'b1, 12'd8, 64'd1);
        mem[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        do_amo("R3 minu", 5'b11000, 1'b1, 12'd8, 64'd1);
        mem[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        do_amo("R3 max signed", 5'b10100, 1'b1, 12'd8, 64'd1);
        mem[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        do_amo("R3 maxu", 5'b11100, 1'b1, 12'd8, 64'd1);
        mem[2] = 64'h0000_0005_8000_0000;
        do_amo("R3 word min signed", 5'b10000, 1'b0, 12'd16, 64'd3);
        mem[2] = 64'h0000_0005_8000_0000;
        do_amo("R3 word maxu", 5'b11100, 1'b0, 12'd16, 64'h7FFF_FFFF);
    endtask

    task automatic t_word;
        mem[2] = 64'h8765_4321_9ABC_DEF0;
        do_amo("R4 word add low", 5'b00000, 1'b0, 12'd16, 64'hFFFF_FFFF_0000_0010);
        do_amo("R4 word swap high", 5'b00001, 1'b0, 12'd20, 64'h1234_5678_CAFE_F00D);
        do_amo("R4 word xor high", 5'b00100, 1'b0, 12'd20, 64'h0000_0000_FFFF_0000);
        do_amo("R4 word max low", 5'b10100, 1'b0, 12'd16, 64'h0000_0000_7000_0000);
    endtask

    task automatic t_lr_sc;
        logic [63:0] rd, old; logic e; int cyc, r0, w0;
        mem[3] = 64'hC000_0000_1234_5678;
        r0 = rd_cnt; w0 = wr_cnt;
        run_op(5'b00010, 3'b011, 12'd24, 64'd0, rd, e, cyc);
        chk("R6 lr value", rd, 64'hC000_0000_1234_5678);
        chk("R6 lr latency", 64'(cyc), 64'd3);
        chk("R6 lr one read no write", 64'((rd_cnt - r0) * 16 + (wr_cnt - w0)), 64'd16);
        run_op(5'b00011, 3'b011, 12'd24, 64'h5555_6666_7777_8888, rd, e, cyc);
        chk("R7 sc success status", rd, 64'd0);
        chk("R7 sc success mem", mem[3], 64'h5555_6666_7777_8888);
        chk("R7 sc latency", 64'(cyc), 64'd2);
        w0 = wr_cnt;
        run_op(5'b00011, 3'b011, 12'd24, 64'h1, rd, e, cyc);
        chk("R7 second sc fails", rd, 64'd1);
        chk("R7 second sc no write", 64'(wr_cnt - w0), 0);
        run_op(5'b00010, 3'b010, 12'd28, 64'd0, rd, e, cyc);
        chk("R6 lr word high sign-extended", rd, 64'h0000_0000_5555_6666);
        old = mem[4];
        run_op(5'b00011, 3'b010, 12'd32, 64'h9, rd, e, cyc);
        chk("R7 sc other address fails", rd, 64'd1);
        chk("R7 sc other address mem kept", mem[4], old);
        old = mem[3];
        run_op(5'b00011, 3'b010, 12'd28, 64'h9, rd, e, cyc);
        chk("R7 reservation cleared by failed sc", rd, 64'd1);
        chk("R7 mem kept after clear", mem[3], old);
        run_op(5'b00010, 3'b010, 12'd28, 64'd0, rd, e, cyc);
        run_op(5'b00011, 3'b010, 12'd28, 64'hABCD_0123, rd, e, cyc);
        chk("R7 word sc success", rd, 64'd0);
        chk("R7 word sc mem", mem[3], {32'hABCD_0123, old[31:0]});
    endtask

    task automatic t_err(input string req, input logic [4:0] f5, input logic [2:0] f3,
                         input logic [11:0] a);
        logic [63:0] rd; logic e; int cyc, r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        run_op(f5, f3, a, 64'h77, rd, e, cyc);
        chk({req, " err"}, 64'(e), 64'd1);
        chk({req, " rd zero"}, rd, 64'd0);
        chk({req, " latency"}, 64'(cyc), 64'd1);
        chk({req, " no access"}, 64'((rd_cnt - r0) + (wr_cnt - w0)), 64'd0);
    endtask

    task automatic t_collide;
        logic [63:0] old5, exp1; int r0, w0;
        old5 = mem[5]; exp1 = mem[1] + 64'd5;
        r0 = rd_cnt; w0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_funct5 = 5'b00000; req_funct3 = 3'b011;
        req_addr = 12'd8; req_rs2 = 64'd5;
        @(negedge clk);
        req_funct5 = 5'b00001; req_addr = 12'd40; req_rs2 = 64'hDEAD;
        repeat (4) @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 request during busy and done ignored", mem[5], old5);
        chk("R5 first op completed", mem[1], exp1);
        chk("R5 single read and write", 64'((rd_cnt - r0) * 16 + (wr_cnt - w0)), 64'd17);
        chk("R5 idle afterwards", 64'(busy), 0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++)
            mem[i] = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_0101_0101_0101);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_dword;
        t_minmax;
        t_word;
        t_lr_sc;
        t_err("R8 word misaligned", 5'b00000, 3'b010, 12'd18);
        t_err("R8 dword misaligned", 5'b00001, 3'b011, 12'd12);
        t_err("R8 sc misaligned", 5'b00011, 3'b011, 12'd4);
        t_err("R9 bad opcode", 5'b00101, 3'b011, 12'd8);
        t_err("R9 bad width", 5'b00000, 3'b000, 12'd8);
        t_collide;
        chk("R10 no simultaneous strobes", 64'(both_cnt), 0);
        chk("R10 done is one cycle", 64'(dbl_done), 0);
        finish_run;
    end

    initial begin
        #(8 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run;
    end
endmodule